// File: doc/BRIEF.md
# Page Re-encryption Progress Tracker

When the per-line write counter of one line in a page overflows, every line of that page has to be encrypted again under a new page-wide major counter. This block drives that sweep and records how far it has got. It latches the page address and the major counter that was in force before the overflow. It keeps one completion bit per line and asks an external line engine to re-encrypt lines one at a time. A line's bit is set only when the write queue reports that the encrypted data line and its updated counter line went in together as one atomic pair.

All of the tracker's state appears on output ports so that a persistence domain can save it across a power failure. A load port puts the saved state back after a restart. The sequencer that runs a fresh sweep also serves recovery: it always asks for the lowest line whose bit is still clear. Recovery tools can query any line to learn whether that line must still be decrypted with the old major counter together with its unchanged per-line counter.

Top module: `reenc_tracker`

## Requirements
- R1: After reset, st_busy is 0, st_vec is all zero, start_ready is 1, req_valid is 0 and query_old is 0.
- R2: start_ready is 1 only while the tracker is idle and no load is presented. An accepted start sets st_busy, latches start_page and start_major into st_page and st_major, and clears st_vec, all visible one cycle later. While busy, start_ready stays 0 and start_page and start_major have no effect.
- R3: Bit i of st_vec (bit i means line i; 1 means already under the new counter) is set only by a commit_valid pulse whose commit_line equals the line of the request that was handshaken last. A commit for any other line, or one with no request outstanding, leaves st_vec unchanged.
- R4: While busy, the tracker requests lines in ascending index order. It skips lines whose bit is already set. At most one request is outstanding, and req_page equals st_page.
- R5: Once req_valid is raised, it stays high and req_line stays unchanged until req_ready is sampled high.
- R6: One cycle after the cycle in which st_vec becomes all ones, st_busy and st_vec both return to zero and start_ready returns to 1.
- R7: st_busy, st_page, st_major and st_vec show the tracker's complete internal state at all times.
- R8: A load_valid pulse replaces busy, page, major and vector with load_busy, load_page, load_major and load_vec. It takes priority over a start in the same cycle, drops any request in flight so that a late commit for it is ignored, and issuing resumes from the lowest clear line.
- R9: query_old is 1 exactly when st_busy is 1 and bit query_line of st_vec is 0.
- R10: A load of a busy state whose vector is already all ones issues no request and returns to idle one cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Counter overflow: begin a page sweep |
| start_ready | output | 1 | Tracker can accept a new sweep |
| start_page | input | PAGE_W | Page to re-encrypt |
| start_major | input | MAJOR_W | Major counter in force before the overflow |
| req_valid | output | 1 | Re-encrypt request to the line engine |
| req_ready | input | 1 | Line engine accepts the request |
| req_page | output | PAGE_W | Page of the requested line |
| req_line | output | LINE_W | Index of the requested line |
| commit_valid | input | 1 | Data and counter pair committed atomically |
| commit_line | input | LINE_W | Line whose pair was committed |
| load_valid | input | 1 | Restore saved state |
| load_busy | input | 1 | Saved busy flag |
| load_page | input | PAGE_W | Saved page |
| load_major | input | MAJOR_W | Saved old major counter |
| load_vec | input | LINES | Saved completion vector |
| st_busy | output | 1 | Sweep in progress |
| st_page | output | PAGE_W | Page being swept |
| st_major | output | MAJOR_W | Old major counter |
| st_vec | output | LINES | Completion vector |
| query_line | input | LINE_W | Line to query |
| query_old | output | 1 | Queried line still uses the old counters |

## Verification
Several corner cases are targeted. A start presented mid-sweep must not overwrite the page; a design without back-pressure would lose the page. A commit for the wrong line, or a commit that arrives too late after a restore, must be ignored; a design that set bits on any commit would mark lines done whose data was never written. The bench holds req_ready low to show that a design which moved on would drop requests. It also restores a sparse vector in the middle of a request to show the sweep restarts at the lowest clear line, and restores a full vector to show a sweep with nothing left ends without issuing a stray request.

// File: rtl/reenc_pkg.sv
package reenc_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/reenc_vector.sv
module reenc_vector #(
   parameter int LINES          = 64,
   parameter int GROUP          = 8,
   parameter bit FIND_TWO_LEVEL = 1'b1,
   localparam int LINE_W        = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [LINES-1:0]  load_vec,
   input  logic              clear_en,
   input  logic              set_en,
   input  logic [LINE_W-1:0] set_idx,
   output logic [LINES-1:0]  vec,
   output logic              full,
   output logic              any_clear,
   output logic [LINE_W-1:0] first_clear
);

   initial begin
      assert (LINES >= 4 && (1 << LINE_W) == LINES)
         else $error("reenc_vector: LINES must be a power of two, at least 4");
      assert (!FIND_TWO_LEVEL || (GROUP >= 2 && (LINES % GROUP) == 0 && (LINES / GROUP) >= 2
              && (1 << $clog2(GROUP)) == GROUP))
         else $error("reenc_vector: GROUP must be a power of two dividing LINES into two or more groups");
   end

   // one completion flop per line
   for (genvar i = 0; i < LINES; i++) begin : g_bit
      logic done_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      done_q <= 1'b0;
         else if (load_en)                                done_q <= load_vec[i];
         else if (clear_en)                               done_q <= 1'b0;
         else if (set_en && set_idx == LINE_W'(i))        done_q <= 1'b1;
      end
      assign vec[i] = done_q;
   end

   assign full = &vec;

   if (FIND_TWO_LEVEL) begin : g_find_tree
      localparam int NGROUP = LINES / GROUP;
      localparam int GW     = $clog2(GROUP);
      localparam int SW     = $clog2(NGROUP);
      logic [NGROUP-1:0] grp_open;
      logic [SW-1:0]     grp_sel;
      logic [GROUP-1:0]  slice;
      logic [GW-1:0]     inner;

      for (genvar g = 0; g < NGROUP; g++) begin : g_grp
         assign grp_open[g] = ~&vec[g*GROUP +: GROUP];
      end

      always_comb begin
         grp_sel = '0;
         for (int g = NGROUP - 1; g >= 0; g--) begin
            if (grp_open[g]) grp_sel = SW'(g);
         end
      end

      assign slice = vec[int'(grp_sel)*GROUP +: GROUP];

      always_comb begin
         inner = '0;
         for (int b = GROUP - 1; b >= 0; b--) begin
            if (!slice[b]) inner = GW'(b);
         end
      end

      assign any_clear   = |grp_open;
      assign first_clear = {grp_sel, inner};
   end else begin : g_find_flat
      logic              lin_any;
      logic [LINE_W-1:0] lin_idx;
      always_comb begin
         lin_any = 1'b0;
         lin_idx = '0;
         for (int i = LINES - 1; i >= 0; i--) begin
            if (!vec[i]) begin
               lin_any = 1'b1;
               lin_idx = LINE_W'(i);
            end
         end
      end
      assign any_clear   = lin_any;
      assign first_clear = lin_idx;
   end

   // R3: a bit may only rise in the cycle after a qualified commit
   p_bit_needs_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_en) && !$past(set_en)) |-> ((vec & ~$past(vec)) == '0))
      else $error("p_bit_needs_commit_r3");

endmodule

// File: rtl/reenc_sequencer.sv
module reenc_sequencer
   import reenc_pkg::*;
#(
   parameter int LINES   = 64,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              abort,
   input  logic              any_clear,
   input  logic [LINE_W-1:0] first_clear,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [LINE_W-1:0] req_line,
   input  logic              commit_valid,
   input  logic [LINE_W-1:0] commit_line,
   output logic              commit_hit
);

   seq_state_e        state_q;
   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         line_q  <= '0;
      end else if (abort) begin
         state_q <= SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (busy && any_clear) begin
                  state_q <= SEQ_ISSUE;
                  line_q  <= first_clear;
               end
            end
            SEQ_ISSUE: begin
               if (req_ready) state_q <= SEQ_WAIT;
            end
            SEQ_WAIT: begin
               if (commit_valid && commit_line == line_q) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign req_valid  = (state_q == SEQ_ISSUE);
   assign req_line   = line_q;
   assign commit_hit = (state_q == SEQ_WAIT) && commit_valid && (commit_line == line_q) && !abort;

   // R5: an unaccepted request holds its line
   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !abort) |=> (req_valid && $stable(req_line)))
      else $error("p_req_hold_r5");

endmodule

// File: rtl/reenc_tracker.sv
module reenc_tracker #(
   parameter int LINES          = 64,
   parameter int PAGE_W         = 36,
   parameter int MAJOR_W        = 64,
   parameter int GROUP          = 8,
   parameter bit FIND_TWO_LEVEL = 1'b1,
   localparam int LINE_W        = $clog2(LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_valid,
   output logic               start_ready,
   input  logic [PAGE_W-1:0]  start_page,
   input  logic [MAJOR_W-1:0] start_major,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [PAGE_W-1:0]  req_page,
   output logic [LINE_W-1:0]  req_line,
   input  logic               commit_valid,
   input  logic [LINE_W-1:0]  commit_line,
   input  logic               load_valid,
   input  logic               load_busy,
   input  logic [PAGE_W-1:0]  load_page,
   input  logic [MAJOR_W-1:0] load_major,
   input  logic [LINES-1:0]   load_vec,
   output logic               st_busy,
   output logic [PAGE_W-1:0]  st_page,
   output logic [MAJOR_W-1:0] st_major,
   output logic [LINES-1:0]   st_vec,
   input  logic [LINE_W-1:0]  query_line,
   output logic               query_old
);

   initial begin
      assert (PAGE_W >= 1 && MAJOR_W >= 1)
         else $error("reenc_tracker: PAGE_W and MAJOR_W must be positive");
   end

   logic               busy_q;
   logic [PAGE_W-1:0]  page_q;
   logic [MAJOR_W-1:0] major_q;
   logic               start_fire;
   logic               finish;
   logic               full;
   logic               any_clear;
   logic [LINE_W-1:0]  first_clear;
   logic               commit_hit;
   logic [LINES-1:0]   vec;

   assign start_ready = !busy_q && !load_valid;
   assign start_fire  = start_valid && start_ready;
   assign finish      = busy_q && full && !load_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         page_q  <= '0;
         major_q <= '0;
      end else if (load_valid) begin
         busy_q  <= load_busy;
         page_q  <= load_page;
         major_q <= load_major;
      end else if (finish) begin
         busy_q  <= 1'b0;
      end else if (start_fire) begin
         busy_q  <= 1'b1;
         page_q  <= start_page;
         major_q <= start_major;
      end
   end

   reenc_vector #(
      .LINES          (LINES),
      .GROUP          (GROUP),
      .FIND_TWO_LEVEL (FIND_TWO_LEVEL)
   ) u_vector (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_en     (load_valid),
      .load_vec    (load_vec),
      .clear_en    (start_fire || finish),
      .set_en      (commit_hit),
      .set_idx     (commit_line),
      .vec         (vec),
      .full        (full),
      .any_clear   (any_clear),
      .first_clear (first_clear)
   );

   reenc_sequencer #(
      .LINES (LINES)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .busy         (busy_q),
      .abort        (load_valid),
      .any_clear    (any_clear),
      .first_clear  (first_clear),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_line     (req_line),
      .commit_valid (commit_valid),
      .commit_line  (commit_line),
      .commit_hit   (commit_hit)
   );

   assign req_page  = page_q;
   assign st_busy   = busy_q;
   assign st_page   = page_q;
   assign st_major  = major_q;
   assign st_vec    = vec;
   assign query_old = busy_q && !vec[query_line];

   // R2: an accepted start yields a busy tracker with an empty vector
   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid && start_ready) |=> (st_busy && st_vec == '0))
      else $error("p_start_clears_r2");

   // R3: completion bits never drop in the middle of a sweep
   p_bits_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_q) && !$past(load_valid) && !$past(finish)) |-> (($past(vec) & ~vec) == '0))
      else $error("p_bits_hold_r3");

   // R4: the requested line is always one that is still pending
   p_req_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (busy_q && !vec[req_line]))
      else $error("p_req_pending_r4");

   // R6: a full vector empties and releases the tracker on the next cycle
   p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && full && !load_valid) |=> (!busy_q && vec == '0))
      else $error("p_done_clears_r6");

endmodule

// File: tb/reenc_tracker_bench.sv
module reenc_tracker_bench;

   localparam int LINES   = 64;
   localparam int PAGE_W  = 36;
   localparam int MAJOR_W = 64;
   localparam int LINE_W  = $clog2(LINES);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_valid = 1'b0;
   logic               start_ready;
   logic [PAGE_W-1:0]  start_page = '0;
   logic [MAJOR_W-1:0] start_major = '0;
   logic               req_valid;
   logic               req_ready = 1'b0;
   logic [PAGE_W-1:0]  req_page;
   logic [LINE_W-1:0]  req_line;
   logic               commit_valid = 1'b0;
   logic [LINE_W-1:0]  commit_line = '0;
   logic               load_valid = 1'b0;
   logic               load_busy = 1'b0;
   logic [PAGE_W-1:0]  load_page = '0;
   logic [MAJOR_W-1:0] load_major = '0;
   logic [LINES-1:0]   load_vec = '0;
   logic               st_busy;
   logic [PAGE_W-1:0]  st_page;
   logic [MAJOR_W-1:0] st_major;
   logic [LINES-1:0]   st_vec;
   logic [LINE_W-1:0]  query_line = '0;
   logic               query_old;

   int checks = 0;
   int fails  = 0;
   logic [PAGE_W-1:0] exp_page = '0;

   always #2 clk = ~clk;

   reenc_tracker u_reenc_tracker (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .start_page(start_page), .start_major(start_major),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_page(req_page), .req_line(req_line),
      .commit_valid(commit_valid), .commit_line(commit_line),
      .load_valid(load_valid), .load_busy(load_busy), .load_page(load_page),
      .load_major(load_major), .load_vec(load_vec),
      .st_busy(st_busy), .st_page(st_page), .st_major(st_major), .st_vec(st_vec),
      .query_line(query_line), .query_old(query_old)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // wait for a request, accept it, then commit the matching pair
   task automatic serve_line(input int exp_line);
      int waited = 0;
      while (!req_valid && waited < 40) begin
         @(negedge clk);
         waited++;
      end
      check(req_valid, "R4", "request issued", 64'(req_valid), 64'd1);
      check(req_line == LINE_W'(exp_line), "R4", "ascending line order", 64'(req_line), 64'(exp_line));
      check(req_page == exp_page, "R4", "request page", 64'(req_page), 64'(exp_page));
      req_ready = 1'b1;
      @(negedge clk);
      req_ready   = 1'b0;
      commit_valid = 1'b1;
      commit_line  = LINE_W'(exp_line);
      @(negedge clk);
      commit_valid = 1'b0;
      check(st_vec[exp_line] == 1'b1, "R3", "bit set on commit", 64'(st_vec[exp_line]), 64'd1);
   endtask

   task automatic begin_page(input logic [PAGE_W-1:0] pg, input logic [MAJOR_W-1:0] mj);
      @(negedge clk);
      start_page  = pg;
      start_major = mj;
      start_valid = 1'b1;
      check(start_ready == 1'b1, "R2", "ready while idle", 64'(start_ready), 64'd1);
      @(negedge clk);
      start_valid = 1'b0;
      exp_page    = pg;
      check(st_busy == 1'b1, "R2", "busy after start", 64'(st_busy), 64'd1);
      check(st_page == pg, "R7", "page latched", 64'(st_page), 64'(pg));
      check(st_major == mj, "R7", "old major latched", st_major, mj);
      check(st_vec == '0, "R2", "vector cleared", st_vec, 64'd0);
      check(start_ready == 1'b0, "R2", "back-pressure while busy", 64'(start_ready), 64'd0);
   endtask

   task automatic test_reset();
      check(st_busy == 1'b0, "R1", "busy after reset", 64'(st_busy), 64'd0);
      check(st_vec == '0, "R1", "vector after reset", st_vec, 64'd0);
      check(start_ready == 1'b1, "R1", "start_ready after reset", 64'(start_ready), 64'd1);
      check(req_valid == 1'b0, "R1", "req_valid after reset", 64'(req_valid), 64'd0);
      check(query_old == 1'b0, "R1", "query_old after reset", 64'(query_old), 64'd0);
   endtask

   task automatic test_fresh_sweep();
      begin_page(36'h0_1234_5000, 64'hDEAD_BEEF_0000_0007);
      for (int l = 0; l < 3; l++) serve_line(l);
      // start while busy must be held off
      start_valid = 1'b1;
      start_page  = 36'h0_9999_9000;
      start_major = 64'h1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(start_ready == 1'b0, "R2", "start blocked while busy", 64'(start_ready), 64'd0);
      end
      start_valid = 1'b0;
      check(st_page == exp_page, "R2", "page not overwritten", 64'(st_page), 64'(exp_page));
      check(st_major == 64'hDEAD_BEEF_0000_0007, "R2", "major not overwritten", st_major, 64'hDEAD_BEEF_0000_0007);
      // hold the request unaccepted
      for (int k = 0; k < 40 && !req_valid; k++) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         check(req_valid == 1'b1, "R5", "request held", 64'(req_valid), 64'd1);
         check(req_line == LINE_W'(3), "R5", "line stable", 64'(req_line), 64'd3);
         @(negedge clk);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready    = 1'b0;
      commit_valid = 1'b1;
      commit_line  = LINE_W'(9);
      @(negedge clk);
      commit_valid = 1'b0;
      check(st_vec == 64'h7, "R3", "wrong-line commit ignored", st_vec, 64'h7);
      commit_valid = 1'b1;
      commit_line  = LINE_W'(3);
      @(negedge clk);
      commit_valid = 1'b0;
      check(st_vec == 64'hF, "R3", "matching commit sets bit", st_vec, 64'hF);
      query_line = LINE_W'(1);
      #1;
      check(query_old == 1'b0, "R9", "done line not old", 64'(query_old), 64'd0);
      query_line = LINE_W'(40);
      #1;
      check(query_old == 1'b1, "R9", "pending line old", 64'(query_old), 64'd1);
      for (int l = 4; l < LINES; l++) serve_line(l);
      check(st_busy == 1'b1 && st_vec == '1, "R6", "full vector before release", st_vec, '1);
      @(negedge clk);
      check(st_busy == 1'b0, "R6", "busy released", 64'(st_busy), 64'd0);
      check(st_vec == '0, "R6", "vector cleared on finish", st_vec, 64'd0);
      check(start_ready == 1'b1, "R6", "ready after finish", 64'(start_ready), 64'd1);
      check(query_old == 1'b0, "R9", "no old line when idle", 64'(query_old), 64'd0);
   endtask

   task automatic test_restore_midway();
      logic [LINES-1:0] model;
      int               nxt;
      begin_page(36'h0_0000_A000, 64'h55);
      for (int k = 0; k < 40 && !req_valid; k++) @(negedge clk);
      check(req_line == '0, "R4", "first line of fresh page", 64'(req_line), 64'd0);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      model = '0;
      model[1] = 1'b1; model[2] = 1'b1; model[5] = 1'b1; model[10] = 1'b1; model[63] = 1'b1;
      load_valid  = 1'b1;
      load_busy   = 1'b1;
      load_page   = 36'h0_0000_C000;
      load_major  = 64'h0123_4567_89AB_CDEF;
      load_vec    = model;
      start_valid = 1'b1;
      start_page  = 36'h0_0000_F000;
      #1;
      check(start_ready == 1'b0, "R8", "load beats start", 64'(start_ready), 64'd0);
      @(negedge clk);
      load_valid  = 1'b0;
      start_valid = 1'b0;
      exp_page    = 36'h0_0000_C000;
      check(st_busy == 1'b1, "R8", "busy restored", 64'(st_busy), 64'd1);
      check(st_page == 36'h0_0000_C000, "R8", "page restored", 64'(st_page), 64'h0_0000_C000);
      check(st_major == 64'h0123_4567_89AB_CDEF, "R8", "major restored", st_major, 64'h0123_4567_89AB_CDEF);
      check(st_vec == model, "R8", "vector restored", st_vec, model);
      // late commit for the abandoned request
      commit_valid = 1'b1;
      commit_line  = '0;
      @(negedge clk);
      commit_valid = 1'b0;
      check(st_vec == model, "R8", "stale commit ignored", st_vec, model);
      while (model != '1) begin
         nxt = 0;
         for (int i = LINES - 1; i >= 0; i--) if (!model[i]) nxt = i;
         serve_line(nxt);
         model[nxt] = 1'b1;
         check(st_vec == model, "R4", "resume skips done lines", st_vec, model);
      end
      @(negedge clk);
      check(st_busy == 1'b0, "R6", "resumed sweep finishes", 64'(st_busy), 64'd0);
   endtask

   task automatic test_restore_full();
      bit saw_req = 1'b0;
      @(negedge clk);
      load_valid = 1'b1;
      load_busy  = 1'b1;
      load_page  = 36'h0_0000_D000;
      load_major = 64'h9;
      load_vec   = '1;
      @(negedge clk);
      load_valid = 1'b0;
      saw_req = req_valid;
      check(st_busy == 1'b1 && st_vec == '1, "R10", "full state loaded", st_vec, '1);
      @(negedge clk);
      saw_req = saw_req | req_valid;
      check(st_busy == 1'b0, "R10", "idle after full load", 64'(st_busy), 64'd0);
      check(st_vec == '0, "R10", "vector cleared after full load", st_vec, 64'd0);
      @(negedge clk);
      saw_req = saw_req | req_valid;
      check(!saw_req, "R10", "no request for full vector", 64'(saw_req), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_fresh_sweep();
      test_restore_midway();
      test_restore_full();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule